// File: doc/BRIEF.md
# Page-Aware Serial Flash Program and Read Sequencer

This block turns one host request into the full series of commands that a serial NOR flash needs. A request carries a direction (program or read), a start byte address and a byte count. A program request is split into chunks, and no chunk crosses a program-page boundary. Every chunk is opened by a write-enable command. After every chunk the block polls the status register until the flash reports that it is idle. When the whole request ends, a write-disable command closes it. A read request is split into chunks of bounded size, and each read chunk is also followed by a readiness poll.

The block does not move any data bytes itself. It drives a transfer engine through a one-command-at-a-time interface. Each command has an opcode, an address-enable flag, an address and a byte count. A one-cycle start pulse launches the command, and the engine answers with a done pulse. For a status read, the engine also returns the status byte. A request that falls partly or wholly outside the device is refused with a range error and issues no commands. If the flash stays busy for more status polls than a limit set per request, the block abandons the remaining chunks and reports a timeout. A program request still receives its closing write-disable in that case.

Top module: `flash_prog_seq`

## Requirements
- R1: A request whose address is at or beyond the device size, or whose address plus length exceeds the device size, finishes with `req_err` = 1 (range error). It raises `req_done` for exactly one cycle and issues no command.
- R2: A request of length zero within range finishes with `req_err` = 0 and a one-cycle `req_done`, and issues no command.
- R3: Each program chunk uses opcode 0x02 with the address enabled. Its length is the smaller of (page size − address mod page size) and the remaining byte count. The next chunk starts at the previous address plus that length.
- R4: Each program chunk is immediately preceded by a write-enable command: opcode 0x06, address flag 0, address 0, length 0.
- R5: After each chunk the block issues status reads (opcode 0x05, address flag 0, length 1). It repeats them while `cmd_rdata & WIP_MASK` (bit 0 by default) is non-zero and moves on after the first poll that reads idle.
- R6: Read requests use opcode 0x03 with the address enabled, in chunks of at most 512 bytes. Every read chunk is followed by the polling of R5. No write-enable and no write-disable are issued for reads.
- R7: Every program request that issued commands ends with one write-disable command (opcode 0x04, address flag 0, length 0) before `req_done`. This holds after a timeout too.
- R8: Within one polling phase, if the number of consecutive busy results exceeds `poll_limit`, the request ends with `req_err` = 2. No further chunk is issued, and only the R7 write-disable may follow. Exactly `poll_limit` busy results are not an error.
- R9: After reset, `req_busy`, `req_done`, `cmd_start` and `req_err` are 0. `cmd_start` is a single-cycle pulse, and a new command starts only after the previous one's `cmd_done`.
- R10: `req_valid` asserted while a request is in progress is ignored. The command series and the result are those of the running request alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Start a request (sampled while idle) |
| req_write | input | 1 | 1 = program, 0 = read |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | LEN_W | Byte count |
| poll_limit | input | POLL_W | Allowed consecutive busy polls per phase |
| req_busy | output | 1 | A request is in progress |
| req_done | output | 1 | One-cycle completion pulse |
| req_err | output | 2 | 0 none, 1 range, 2 timeout; held until next request |
| cmd_start | output | 1 | One-cycle command launch |
| cmd_opcode | output | 8 | Command opcode |
| cmd_addr_en | output | 1 | Command carries an address |
| cmd_addr | output | ADDR_W | Command address |
| cmd_len | output | CLEN_W | Command data byte count |
| cmd_done | input | 1 | Engine finished the command |
| cmd_rdata | input | 8 | Status byte returned by a status read |

## Verification
The timeout detection and the end of a chunk's polling phase can land on the same status result. The poll that exhausts the busy allowance can also be the one that would let the last chunk finish. The bench sets the engine model's busy count equal to `poll_limit`, which must succeed, and one above it, which must time out. It runs both on single-chunk and multi-chunk requests. The full recorded command series and the error code are compared against a model built from the requirements, including whether the write-disable still follows.

// File: rtl/flash_seq_pkg.sv
`timescale 1ns/1ps
package flash_seq_pkg;

    localparam logic [7:0] OP_WREN = 8'h06;
    localparam logic [7:0] OP_WRDI = 8'h04;
    localparam logic [7:0] OP_RDSR = 8'h05;
    localparam logic [7:0] OP_PROG = 8'h02;
    localparam logic [7:0] OP_READ = 8'h03;

    typedef enum logic [1:0] {
        ERR_NONE    = 2'd0,
        ERR_RANGE   = 2'd1,
        ERR_TIMEOUT = 2'd2
    } seq_err_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_WREN,
        S_WREN_W,
        S_XFER,
        S_XFER_W,
        S_POLL,
        S_POLL_W,
        S_WRDI,
        S_WRDI_W
    } seq_state_e;

endpackage

// File: rtl/fseq_range_check.sv
`timescale 1ns/1ps
module fseq_range_check #(
    parameter int              ADDR_W    = 24,
    parameter int              LEN_W     = 24,
    parameter longint unsigned DEV_BYTES = 64'd1048576
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]  len,
    output logic              out_of_range,
    output logic              empty
);
    localparam int SW = ((ADDR_W > LEN_W) ? ADDR_W : LEN_W) + 2;

    logic [SW-1:0] addr_x;
    logic [SW-1:0] len_x;
    logic [SW-1:0] dev_x;

    always_comb begin
        addr_x       = SW'(addr);
        len_x        = SW'(len);
        dev_x        = SW'(DEV_BYTES);
        // The subtraction only matters when addr_x < dev_x, so no underflow reaches the result
        out_of_range = (addr_x >= dev_x) || (len_x > (dev_x - addr_x));
        empty        = (len == '0);
    end
endmodule

// File: rtl/fseq_chunk.sv
`timescale 1ns/1ps
module fseq_chunk #(
    parameter int ADDR_W     = 24,
    parameter int LEN_W      = 24,
    parameter int PAGE_BYTES = 256,
    parameter int RD_MAX     = 512,
    parameter int CLEN_W     = 10
) (
    input  logic              is_prog,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]  remain,
    output logic [CLEN_W-1:0] chunk
);
    localparam int PG_W = (PAGE_BYTES > 1) ? $clog2(PAGE_BYTES) : 1;

    logic [PG_W-1:0] offset;
    logic [PG_W:0]   room;
    logic [CLEN_W-1:0] cap;

    generate
        if ((PAGE_BYTES & (PAGE_BYTES - 1)) == 0) begin : g_pow2
            // Power-of-two page: the offset is the low address bits
            assign offset = addr[PG_W-1:0];
        end else begin : g_mod
            assign offset = PG_W'(addr % ADDR_W'(PAGE_BYTES));
        end
    endgenerate

    always_comb begin
        room  = (PG_W+1)'(PAGE_BYTES) - {1'b0, offset};
        cap   = is_prog ? CLEN_W'(room) : CLEN_W'(RD_MAX);
        chunk = (remain < LEN_W'(cap)) ? CLEN_W'(remain) : cap;
    end
endmodule

// File: rtl/fseq_poll_timer.sv
`timescale 1ns/1ps
module fseq_poll_timer #(
    parameter int POLL_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              sample,
    input  logic              busy_bit,
    input  logic [POLL_W-1:0] limit,
    output logic              expire
);
    logic [POLL_W-1:0] cnt_d, cnt_q;

    always_comb begin
        expire = sample && busy_bit && (cnt_q == limit);
        cnt_d  = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (sample) begin
            cnt_d = busy_bit ? (expire ? cnt_q : cnt_q + 1'b1) : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R8: a busy result beyond the allowance is always flagged, never counted past it
    a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (sample && busy_bit && !clear && (cnt_q == limit)) |=> (cnt_q == $past(cnt_q)));
endmodule

// File: rtl/flash_prog_seq.sv
`timescale 1ns/1ps
module flash_prog_seq
    import flash_seq_pkg::*;
#(
    parameter int              ADDR_W     = 24,
    parameter int              LEN_W      = 24,
    parameter longint unsigned DEV_BYTES  = 64'd1048576,
    parameter int              PAGE_BYTES = 256,
    parameter int              RD_MAX     = 512,
    parameter int              POLL_W     = 16,
    parameter logic [7:0]      WIP_MASK   = 8'h01,
    parameter int              CLEN_W     = $clog2(((PAGE_BYTES > RD_MAX) ? PAGE_BYTES : RD_MAX) + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [POLL_W-1:0] poll_limit,
    output logic              req_busy,
    output logic              req_done,
    output logic [1:0]        req_err,
    output logic              cmd_start,
    output logic [7:0]        cmd_opcode,
    output logic              cmd_addr_en,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [CLEN_W-1:0] cmd_len,
    input  logic              cmd_done,
    input  logic [7:0]        cmd_rdata
);
    typedef struct packed {
        seq_state_e        st;
        logic              prog;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  remain;
        logic [CLEN_W-1:0] chunk;
        seq_err_e          err;
        logic              done;
        logic              start;
        logic [7:0]        opcode;
        logic              aen;
        logic [ADDR_W-1:0] caddr;
        logic [CLEN_W-1:0] clen;
    } seq_regs_t;

    seq_regs_t q, d;

    logic              rng_bad, rng_empty;
    logic [CLEN_W-1:0] chunk_w;
    logic              stat_busy, tmr_clear, tmr_sample, tmr_expire;
    logic              ack;

    fseq_range_check #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .DEV_BYTES(DEV_BYTES)
    ) u_range (
        .addr(req_addr), .len(req_len), .out_of_range(rng_bad), .empty(rng_empty)
    );

    fseq_chunk #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES),
        .RD_MAX(RD_MAX), .CLEN_W(CLEN_W)
    ) u_chunk (
        .is_prog(q.prog), .addr(q.addr), .remain(q.remain), .chunk(chunk_w)
    );

    fseq_poll_timer #(.POLL_W(POLL_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .clear(tmr_clear), .sample(tmr_sample),
        .busy_bit(stat_busy), .limit(poll_limit), .expire(tmr_expire)
    );

    assign stat_busy = |(cmd_rdata & WIP_MASK);
    // A done in the launch cycle belongs to no command of ours
    assign ack       = cmd_done && !q.start;

    always_comb begin
        d          = q;
        d.done     = 1'b0;
        d.start    = 1'b0;
        tmr_clear  = 1'b1;
        tmr_sample = 1'b0;
        unique case (q.st)
            S_IDLE: begin
                if (req_valid) begin
                    d.prog   = req_write;
                    d.addr   = req_addr;
                    d.remain = req_len;
                    d.err    = ERR_NONE;
                    if (rng_bad) begin
                        d.err  = ERR_RANGE;
                        d.done = 1'b1;
                    end else if (rng_empty) begin
                        d.done = 1'b1;
                    end else begin
                        d.st = req_write ? S_WREN : S_XFER;
                    end
                end
            end
            S_WREN: begin
                d.start  = 1'b1;
                d.opcode = OP_WREN;
                d.aen    = 1'b0;
                d.caddr  = '0;
                d.clen   = '0;
                d.st     = S_WREN_W;
            end
            S_WREN_W: begin
                if (ack) d.st = S_XFER;
            end
            S_XFER: begin
                d.start  = 1'b1;
                d.opcode = q.prog ? OP_PROG : OP_READ;
                d.aen    = 1'b1;
                d.caddr  = q.addr;
                d.clen   = chunk_w;
                d.chunk  = chunk_w;
                d.st     = S_XFER_W;
            end
            S_XFER_W: begin
                if (ack) begin
                    d.addr   = q.addr + ADDR_W'(q.chunk);
                    d.remain = q.remain - LEN_W'(q.chunk);
                    d.st     = S_POLL;
                end
            end
            S_POLL: begin
                tmr_clear = 1'b0;
                d.start   = 1'b1;
                d.opcode  = OP_RDSR;
                d.aen     = 1'b0;
                d.caddr   = '0;
                d.clen    = CLEN_W'(1);
                d.st      = S_POLL_W;
            end
            S_POLL_W: begin
                tmr_clear = 1'b0;
                if (ack) begin
                    tmr_sample = 1'b1;
                    if (stat_busy) begin
                        if (tmr_expire) begin
                            if (q.err == ERR_NONE) d.err = ERR_TIMEOUT;
                            d.st   = q.prog ? S_WRDI : S_IDLE;
                            d.done = !q.prog;
                        end else begin
                            d.st = S_POLL;
                        end
                    end else if (q.remain == '0) begin
                        d.st   = q.prog ? S_WRDI : S_IDLE;
                        d.done = !q.prog;
                    end else begin
                        d.st = q.prog ? S_WREN : S_XFER;
                    end
                end
            end
            S_WRDI: begin
                d.start  = 1'b1;
                d.opcode = OP_WRDI;
                d.aen    = 1'b0;
                d.caddr  = '0;
                d.clen   = '0;
                d.st     = S_WRDI_W;
            end
            S_WRDI_W: begin
                if (ack) begin
                    d.st   = S_IDLE;
                    d.done = 1'b1;
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.st     <= S_IDLE;
            q.err    <= ERR_NONE;
        end else begin
            q <= d;
        end
    end

    assign req_busy    = (q.st != S_IDLE);
    assign req_done    = q.done;
    assign req_err     = q.err;
    assign cmd_start   = q.start;
    assign cmd_opcode  = q.opcode;
    assign cmd_addr_en = q.aen;
    assign cmd_addr    = q.caddr;
    assign cmd_len     = q.clen;

    // R3: a program chunk is non-empty and stays inside one page
    a_r3_page_fit: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start && cmd_opcode == OP_PROG) |->
            (cmd_addr_en && cmd_len != '0 &&
             (32'(cmd_len) + (32'(cmd_addr) % 32'(PAGE_BYTES))) <= 32'(PAGE_BYTES)));

    // R4: write-enable carries neither address nor data
    a_r4_wren_plain: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start && cmd_opcode == OP_WREN) |-> (!cmd_addr_en && cmd_len == '0));

    // R5: a status poll reads exactly one byte without address
    a_r5_poll_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start && cmd_opcode == OP_RDSR) |-> (!cmd_addr_en && cmd_len == CLEN_W'(1)));

    // R6: a read chunk is non-empty and bounded
    a_r6_read_cap: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start && cmd_opcode == OP_READ) |->
            (cmd_addr_en && cmd_len != '0 && 32'(cmd_len) <= 32'(RD_MAX)));

    // R9: command launch is a single-cycle pulse
    a_r9_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |=> !cmd_start);

    // R2: completion is a single-cycle pulse and leaves the block idle
    a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        req_done |-> (!req_busy ##1 !req_done));

    // R1: a range error never coincides with a command launch
    a_r1_no_cmd_on_range: assert property (@(posedge clk) disable iff (!rst_n)
        (req_done && req_err == 2'd1) |-> !cmd_start);
endmodule

// File: tb/sim_flash_prog_seq.sv
`timescale 1ns/1ps
module sim_flash_prog_seq;
    localparam int     AW    = 24;
    localparam int     LW    = 24;
    localparam int     PW    = 16;
    localparam int     CW    = 10;
    localparam longint DEV   = 64'd1048576;
    localparam int     PAGE  = 256;
    localparam int     RDMAX = 512;
    localparam int     TMAX  = 1024;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [LW-1:0] req_len = '0;
    logic [PW-1:0] poll_limit = '0;
    logic          req_busy, req_done;
    logic [1:0]    req_err;
    logic          cmd_start, cmd_addr_en;
    logic [7:0]    cmd_opcode;
    logic [AW-1:0] cmd_addr;
    logic [CW-1:0] cmd_len;
    logic          cmd_done = 1'b0;
    logic [7:0]    cmd_rdata = 8'h00;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int busy_n = 0;
    int poll_idx = 0;
    longint tr[TMAX];
    int     tr_n = 0;
    longint ex[TMAX];
    int     ex_n = 0;
    int     ex_err = 0;

    always #2 clk = ~clk;

    flash_prog_seq u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_len(req_len), .poll_limit(poll_limit),
        .req_busy(req_busy), .req_done(req_done), .req_err(req_err),
        .cmd_start(cmd_start), .cmd_opcode(cmd_opcode), .cmd_addr_en(cmd_addr_en),
        .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_done(cmd_done), .cmd_rdata(cmd_rdata)
    );

    function automatic longint enc(int op, int aen, int ad, int ln);
        return (longint'(op) << 40) | (longint'(aen) << 36) | (longint'(ad) << 12) | longint'(ln);
    endfunction

    task automatic chk(input bit ok, input string what, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic summary_and_end();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
            summary_and_end();
        end
    end

    // Transfer engine model: records every launched command, answers after a delay
    initial begin
        forever begin
            @(negedge clk);
            if (cmd_start) begin
                if (tr_n < TMAX) tr[tr_n] = enc(int'(cmd_opcode), int'(cmd_addr_en), int'(cmd_addr), int'(cmd_len));
                tr_n++;
                if (cmd_opcode == 8'h05) begin
                    cmd_rdata = {7'($urandom), (poll_idx < busy_n)};
                    poll_idx++;
                end else begin
                    poll_idx = 0;
                    cmd_rdata = 8'($urandom) & 8'hFE;
                end
                repeat ($urandom_range(1, 3)) @(negedge clk);
                cmd_done = 1'b1;
                @(negedge clk);
                cmd_done = 1'b0;
            end
        end
    end

    task automatic push(longint e);
        if (ex_n < TMAX) ex[ex_n] = e;
        ex_n++;
    endtask

    // Expected command series from the requirements
    task automatic build_exp(bit w, longint a, longint l, int bn, int lim);
        longint rem, ad, c;
        bit to;
        ex_n = 0;
        if (a >= DEV || l > DEV - a) begin ex_err = 1; return; end
        ex_err = 0;
        if (l == 0) return;
        rem = l; ad = a; to = 0;
        while (rem > 0 && !to) begin
            if (w) push(enc(8'h06, 0, 0, 0));
            c = w ? (PAGE - (ad % PAGE)) : RDMAX;
            if (rem < c) c = rem;
            push(enc(w ? 8'h02 : 8'h03, 1, int'(ad), int'(c)));
            ad += c; rem -= c;
            if (bn > lim) begin
                for (int i = 0; i <= lim; i++) push(enc(8'h05, 0, 0, 1));
                to = 1;
            end else begin
                for (int i = 0; i <= bn; i++) push(enc(8'h05, 0, 0, 1));
            end
        end
        if (to) ex_err = 2;
        if (w) push(enc(8'h04, 0, 0, 0));
    endtask

    task automatic do_req(bit w, longint a, longint l, int bn, int lim, bit inject, string tag);
        int cnt;
        int bad_i;
        build_exp(w, a, l, bn, lim);
        busy_n = bn;
        poll_limit = PW'(lim);
        tr_n = 0;
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = AW'(a); req_len = LW'(l);
        @(negedge clk);
        req_valid = 1'b0; req_addr = AW'($urandom); req_len = LW'($urandom);
        cnt = 0;
        while (!req_done && cnt < 40000) begin
            @(negedge clk);
            cnt++;
            if (inject && cnt == 3) begin
                req_valid = 1'b1; req_write = !w; req_addr = '0; req_len = LW'(8);
            end else begin
                req_valid = 1'b0;
            end
        end
        req_valid = 1'b0;
        chk(req_done, {tag, " done seen"}, longint'(req_done), 1);
        chk(int'(req_err) == ex_err, {tag, " error code"}, longint'(req_err), longint'(ex_err));
        repeat (6) @(negedge clk);
        chk(!req_busy, {tag, " idle after done"}, longint'(req_busy), 0);
        chk(tr_n == ex_n, {tag, " command count"}, longint'(tr_n), longint'(ex_n));
        bad_i = -1;
        for (int i = 0; i < ex_n && i < tr_n && i < TMAX; i++) begin
            if (bad_i < 0 && tr[i] != ex[i]) bad_i = i;
        end
        if (bad_i >= 0) chk(1'b0, {tag, " command series"}, tr[bad_i], ex[bad_i]);
        else            chk(1'b1, {tag, " command series"}, 0, 0);
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(!req_busy && !req_done && !cmd_start && req_err == 2'd0, "R9 reset state",
            {req_busy, req_done, cmd_start, req_err}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1: range errors, including one byte past the end
        do_req(1, DEV, 4, 0, 2, 0, "R1 addr at end");
        do_req(0, DEV - 10, 11, 0, 2, 0, "R1 one past end");
        do_req(1, DEV + 64'd5000, 0, 0, 2, 0, "R1 outside zero len");
        // R1/R3: request ending exactly at the device end is legal
        do_req(1, DEV - 10, 10, 1, 2, 0, "R1 R3 exact end");
        // R2: zero length
        do_req(1, 64'h100, 0, 0, 2, 0, "R2 zero prog");
        do_req(0, 64'h0, 0, 0, 2, 0, "R2 zero read");
        // R3 R4 R5 R7: unaligned program across several pages
        do_req(1, 64'h1F0, 600, 2, 5, 0, "R3 R4 R5 R7 multi page");
        do_req(1, 64'h300, 256, 0, 0, 0, "R3 aligned full page");
        // R6: read split
        do_req(0, 64'h10, 1300, 1, 3, 0, "R6 read split");
        do_req(0, 64'h20, 512, 0, 1, 0, "R6 read exact cap");
        // R8: busy equal to limit is fine, one above times out
        do_req(1, 64'h1F0, 600, 3, 3, 0, "R8 busy equals limit");
        do_req(1, 64'h1F0, 600, 4, 3, 0, "R8 timeout prog R7");
        do_req(0, 64'h40, 1200, 1, 0, 0, "R8 timeout read");
        // R10: request pulse while busy is ignored
        do_req(1, 64'h2F8, 300, 2, 4, 1, "R10 ignore while busy");
        do_req(0, 64'h500, 900, 1, 2, 1, "R10 ignore during read");

        for (int k = 0; k < 40; k++) begin
            bit w;
            longint a, l;
            int bn, lim;
            w   = 1'($urandom_range(0, 1));
            a   = longint'($urandom_range(0, 32'(DEV - 1)));
            if ($urandom_range(0, 3) == 0) a = (a & ~longint'(PAGE - 1)) + PAGE - $urandom_range(1, 8);
            if ($urandom_range(0, 7) == 0) a = DEV - $urandom_range(0, 40);
            l   = w ? longint'($urandom_range(0, 700)) : longint'($urandom_range(0, 1500));
            bn  = $urandom_range(0, 3);
            lim = $urandom_range(0, 4);
            do_req(w, a, l, bn, lim, 0, "R3 R5 R6 R8 random");
        end

        summary_and_end();
    end
endmodule